// File: doc/BRIEF.md
# Real-Time-Clock Time Base with Periodic Wakeup Timer

This block turns a low-speed reference clock into the time base of a real-time clock. Two programmable divider stages are chained on the reference clock. The first stage is a coarse 7-bit divider. The second stage is a 15-bit divider that advances once for each pulse of the first stage. When the second stage reaches its terminal count, it issues a one-cycle calendar tick. With a 32768 Hz reference and the usual settings, that tick arrives once per second. The second stage's down-counter is brought out as the sub-second count.

A separate wakeup timer sits beside the dividers. It is a 16-bit auto-reload down-counter whose step comes from a small 4-bit prescaler on the reference clock. A 3-bit select field picks the step source: one of four power-of-two divisions of the reference clock, or the calendar tick. Each time the counter expires, it sets a sticky wakeup flag. The flag stays set until a clear strobe is applied. It reaches the interrupt output only when the interrupt mask bit is open.

All logic runs on the reference clock, and the whole block shares one synchronous active-low reset. Configuration values are plain inputs. They are held stable by the surrounding register file.

Top module: `rtc_timebase`

## Requirements
- R1: The first divider stage emits one step for the second stage every `cfg_async_div`+1 reference cycles, so `subsec` can only change on those cycles.
- R2: With `cfg_run` high, `tick_1hz` is high for one cycle every (`cfg_async_div`+1)·(`cfg_sync_div`+1) reference cycles. With settings 127 and 255, the first tick comes 32767 cycles after the first running cycle, and each later tick 32768 cycles after the one before.
- R3: `subsec` is the second stage's down-counter. It falls by one on each first-stage step. In the cycle where it is 0 and a step arrives, `tick_1hz` is high, and on the next edge `subsec` reloads to `cfg_sync_div`.
- R4: While `cfg_run` is low, no tick is produced. Both stages load their programmed values, so `subsec` equals `cfg_sync_div` one cycle later.
- R5: Wakeup select codes 0, 1, 2 and 3 step the wakeup counter once every 16, 8, 4 and 2 reference cycles. Codes 4 to 7 step it on the calendar tick.
- R6: While `cfg_wk_en` is low, the wakeup counter holds `cfg_wk_reload` and its prescaler holds 0, and the flag is never set. Once the timer is enabled with reload R and step period D, the flag is first set D·(R+1) cycles after enabling, and again every D·(R+1) cycles after that.
- R7: `wk_flag` stays set until `wk_clr` is applied. When a clear and an expiry fall in the same cycle, the flag stays set.
- R8: `wk_irq` equals `wk_flag` while `cfg_wk_irq_en` is 1, and it is 0 otherwise.
- R9: During reset, `tick_1hz`, `subsec`, `wk_flag` and `wk_irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-speed reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_run | input | 1 | Runs the two divider stages; low reloads them |
| cfg_async_div | input | 7 | First-stage divide value (divides by value+1) |
| cfg_sync_div | input | 15 | Second-stage divide value (divides by value+1) |
| cfg_wk_en | input | 1 | Wakeup timer enable |
| cfg_wk_sel | input | 3 | Wakeup step source select |
| cfg_wk_reload | input | 16 | Wakeup counter reload value |
| cfg_wk_irq_en | input | 1 | Wakeup interrupt mask (1 = pass) |
| wk_clr | input | 1 | Wakeup flag clear strobe |
| tick_1hz | output | 1 | One-cycle calendar tick |
| subsec | output | 15 | Sub-second down-count |
| wk_flag | output | 1 | Sticky wakeup flag |
| wk_irq | output | 1 | Masked wakeup interrupt |

## Verification
The assertions check several rules on every cycle:
- no tick and a reloaded `subsec` while the dividers are stopped;
- a reload of `subsec` right after each tick;
- a `subsec` that either holds or falls by one, and changes only after a first-stage terminal count;
- a sticky flag, no new flag while the timer is disabled, and the interrupt mask.

Only the bench scenarios can show the exact cycle counts. These are the tick period for several divider pairs (including the 32768-cycle one-second case), the first and second wakeup expiry for each select code, and the outcome when a clear meets an expiry in the same cycle.

// File: rtl/rtc_tb_pkg.sv
// Package: shared widths for the RTC time base.
// Assumes: the wakeup prescaler width fixes how many divided-clock select codes exist.
package rtc_tb_pkg;
    localparam int RTC_ASYNC_W  = 7;
    localparam int RTC_SYNC_W   = 15;
    localparam int RTC_WK_W     = 16;
    localparam int RTC_WK_SEL_W = 3;
    localparam int RTC_WK_PRE_W = 4;
endpackage

// File: rtl/rtc_div_stage.sv
// Module: programmable down-counting divider stage.
// Divides its step input by load_i+1. It emits a terminal-count pulse in the
// step cycle where the count is zero, and reloads on the same edge.
// Assumes: run_i low means the stage is stopped and tracks load_i.
module rtc_div_stage #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_i,
    input  logic         step_i,
    input  logic [W-1:0] load_i,
    output logic [W-1:0] cnt_o,
    output logic         tc_o
);
    logic [W-1:0] cnt_q;
    logic         at_zero;

    assign at_zero = (cnt_q == '0);
    assign tc_o    = run_i & step_i & at_zero;
    assign cnt_o   = cnt_q;

    // Count down on each step, reload at zero, and track the load value while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i) begin
            cnt_q <= load_i;
        end else if (step_i) begin
            cnt_q <= at_zero ? load_i : cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/rtc_wk_clksel.sv
// Module: wakeup step source.
// A free-running PRE_W-bit prescaler gives divisions of the reference clock.
// Code c < PRE_W divides by 2**(PRE_W-c); all higher codes pick the calendar tick.
// Assumes: the prescaler is held at zero while the wakeup timer is disabled.
module rtc_wk_clksel #(
    parameter int PRE_W = 4,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             tick_i,
    output logic             ce_o
);
    localparam int NCODE = 2 ** SEL_W;

    logic [PRE_W-1:0] pre_q;
    logic [NCODE-1:0] sel_ce;

    // Advance the prescaler while enabled, and clear it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (!en_i) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // One enable per select code: a divided clock or the calendar tick.
    for (genvar c = 0; c < NCODE; c++) begin : g_code
        if (c < PRE_W) begin : g_div
            assign sel_ce[c] = &pre_q[PRE_W-1-c:0];
        end else begin : g_tick
            assign sel_ce[c] = tick_i;
        end
    end

    assign ce_o = sel_ce[sel_i];
endmodule

// File: rtl/rtc_wk_timer.sv
// Module: auto-reload wakeup down-counter with a sticky flag.
// Assumes: ce_i is a single-cycle step. Setting the flag wins over clearing it.
module rtc_wk_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic         ce_i,
    input  logic [W-1:0] reload_i,
    input  logic         clr_i,
    output logic         flag_o
);
    logic [W-1:0] cnt_q;
    logic         flag_q;
    logic         expire;

    assign expire = en_i & ce_i & (cnt_q == '0);
    assign flag_o = flag_q;

    // Hold the reload value while disabled, and count down on each step otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en_i) begin
            cnt_q <= reload_i;
        end else if (ce_i) begin
            cnt_q <= (cnt_q == '0) ? reload_i : cnt_q - 1'b1;
        end
    end

    // Sticky flag: set on expiry, otherwise cleared by the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (expire) begin
            flag_q <= 1'b1;
        end else if (clr_i) begin
            flag_q <= 1'b0;
        end
    end
endmodule

// File: rtl/rtc_timebase.sv
// Module: RTC time base top.
// Chains the coarse and fine divider stages to make the calendar tick and the
// sub-second count, and adds the independently selected wakeup timer.
// Assumes: everything runs on the reference clock, and configuration inputs are quasi-static.
module rtc_timebase
    import rtc_tb_pkg::*;
#(
    parameter int ASYNC_W  = RTC_ASYNC_W,
    parameter int SYNC_W   = RTC_SYNC_W,
    parameter int WK_W     = RTC_WK_W,
    parameter int WK_SEL_W = RTC_WK_SEL_W,
    parameter int WK_PRE_W = RTC_WK_PRE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_run,
    input  logic [ASYNC_W-1:0]  cfg_async_div,
    input  logic [SYNC_W-1:0]   cfg_sync_div,
    input  logic                cfg_wk_en,
    input  logic [WK_SEL_W-1:0] cfg_wk_sel,
    input  logic [WK_W-1:0]     cfg_wk_reload,
    input  logic                cfg_wk_irq_en,
    input  logic                wk_clr,
    output logic                tick_1hz,
    output logic [SYNC_W-1:0]   subsec,
    output logic                wk_flag,
    output logic                wk_irq
);
    logic [ASYNC_W-1:0] a_cnt;
    logic               a_tc;
    logic               wk_ce;

    rtc_div_stage #(.W(ASYNC_W)) u_async (
        .clk(clk), .rst_n(rst_n), .run_i(cfg_run), .step_i(1'b1),
        .load_i(cfg_async_div), .cnt_o(a_cnt), .tc_o(a_tc)
    );

    rtc_div_stage #(.W(SYNC_W)) u_sync (
        .clk(clk), .rst_n(rst_n), .run_i(cfg_run), .step_i(a_tc),
        .load_i(cfg_sync_div), .cnt_o(subsec), .tc_o(tick_1hz)
    );

    rtc_wk_clksel #(.PRE_W(WK_PRE_W), .SEL_W(WK_SEL_W)) u_wksel (
        .clk(clk), .rst_n(rst_n), .en_i(cfg_wk_en), .sel_i(cfg_wk_sel),
        .tick_i(tick_1hz), .ce_o(wk_ce)
    );

    rtc_wk_timer #(.W(WK_W)) u_wktmr (
        .clk(clk), .rst_n(rst_n), .en_i(cfg_wk_en), .ce_i(wk_ce),
        .reload_i(cfg_wk_reload), .clr_i(wk_clr), .flag_o(wk_flag)
    );

    assign wk_irq = wk_flag & cfg_wk_irq_en;
endmodule

// File: rtl/rtc_timebase_chk.sv
// Module: property checker for rtc_timebase, attached with bind.
// Assumes: it watches the ports, plus the coarse stage count of the top.
module rtc_timebase_chk #(
    parameter int ASYNC_W = 7,
    parameter int SYNC_W  = 15
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_run,
    input logic [SYNC_W-1:0]  cfg_sync_div,
    input logic               cfg_wk_en,
    input logic               cfg_wk_irq_en,
    input logic               wk_clr,
    input logic               tick_1hz,
    input logic [SYNC_W-1:0]  subsec,
    input logic               wk_flag,
    input logic               wk_irq,
    input logic [ASYNC_W-1:0] a_cnt
);
    p_no_tick_stopped_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_run |-> !tick_1hz);

    p_hold_subsec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_run |=> subsec == $past(cfg_sync_div));

    p_reload_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_1hz && cfg_run) |=> subsec == $past(cfg_sync_div));

    p_subsec_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_run && $past(cfg_run) && !$past(tick_1hz)) |->
        (subsec == $past(subsec) || subsec == $past(subsec) - 1'b1));

    p_subsec_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_run && $past(cfg_run) && subsec != $past(subsec)) |-> $past(a_cnt) == '0);

    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wk_flag && !wk_clr) |=> wk_flag);

    p_no_set_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_wk_en && !wk_flag) |=> !wk_flag);

    p_irq_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wk_irq == (wk_flag && cfg_wk_irq_en));
endmodule

bind rtc_timebase rtc_timebase_chk #(.ASYNC_W(ASYNC_W), .SYNC_W(SYNC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_run(cfg_run), .cfg_sync_div(cfg_sync_div),
    .cfg_wk_en(cfg_wk_en), .cfg_wk_irq_en(cfg_wk_irq_en), .wk_clr(wk_clr),
    .tick_1hz(tick_1hz), .subsec(subsec), .wk_flag(wk_flag), .wk_irq(wk_irq),
    .a_cnt(a_cnt)
);

// File: tb/rtc_timebase_bench.sv
// Bench for rtc_timebase. A table of divider vectors runs first, then directed
// tests cover reset, the stopped state, the one-second period, wakeup selects,
// the clear/expiry race and the interrupt mask.
module rtc_timebase_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 5;
    // Each row: async value, sync value, running cycles, expected ticks, expected subsec.
    localparam int unsigned PV [NVEC][5] = '{
        '{0, 0, 10, 10, 0},
        '{3, 2, 40,  3, 1},
        '{1, 4, 25,  2, 2},
        '{6, 1, 30,  2, 1},
        '{2, 0,  9,  3, 0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_run = 1'b0;
    logic [6:0]  cfg_async_div = '0;
    logic [14:0] cfg_sync_div = '0;
    logic        cfg_wk_en = 1'b0;
    logic [2:0]  cfg_wk_sel = '0;
    logic [15:0] cfg_wk_reload = '0;
    logic        cfg_wk_irq_en = 1'b0;
    logic        wk_clr = 1'b0;
    logic        tick_1hz;
    logic [14:0] subsec;
    logic        wk_flag;
    logic        wk_irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    rtc_timebase u_rtc_timebase (
        .clk(clk), .rst_n(rst_n), .cfg_run(cfg_run), .cfg_async_div(cfg_async_div),
        .cfg_sync_div(cfg_sync_div), .cfg_wk_en(cfg_wk_en), .cfg_wk_sel(cfg_wk_sel),
        .cfg_wk_reload(cfg_wk_reload), .cfg_wk_irq_en(cfg_wk_irq_en), .wk_clr(wk_clr),
        .tick_1hz(tick_1hz), .subsec(subsec), .wk_flag(wk_flag), .wk_irq(wk_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock edge, then settle at the falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Stop everything and leave the wakeup flag cleared.
    task automatic quiesce();
        cfg_run = 1'b0;
        cfg_wk_en = 1'b0;
        wk_clr = 1'b1;
        step();
        wk_clr = 1'b0;
        step();
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int ticks;
        @(negedge clk);
        step();
        // R9: state while reset is held
        chk("R9 tick", tick_1hz, 0);
        chk("R9 subsec", subsec, 0);
        chk("R9 flag", wk_flag, 0);
        chk("R9 irq", wk_irq, 0);
        rst_n = 1'b1;
        step();

        // R2/R3: table of divider vectors
        for (int v = 0; v < NVEC; v++) begin
            quiesce();
            cfg_async_div = 7'(PV[v][0]);
            cfg_sync_div = 15'(PV[v][1]);
            step();
            cfg_run = 1'b1;
            ticks = 0;
            for (int k = 0; k < int'(PV[v][2]); k++) begin
                step();
                if (tick_1hz) ticks++;
            end
            chk($sformatf("R2 tick count vec%0d", v), ticks, PV[v][3]);
            chk($sformatf("R3 subsec vec%0d", v), subsec, PV[v][4]);
        end

        // R4: stopped dividers give no ticks and track the programmed value
        quiesce();
        cfg_async_div = 7'd0;
        cfg_sync_div = 15'd0;
        ticks = 0;
        for (int k = 0; k < 20; k++) begin
            step();
            if (tick_1hz) ticks++;
        end
        chk("R4 no tick when stopped", ticks, 0);
        cfg_sync_div = 15'd77;
        step();
        chk("R4 subsec tracks value", subsec, 77);
        cfg_sync_div = 15'd5;
        step();
        chk("R4 subsec tracks new value", subsec, 5);

        // R1: with a coarse divide of 4, subsec steps once per 4 cycles
        cfg_async_div = 7'd3;
        cfg_sync_div = 15'd9;
        step();
        cfg_run = 1'b1;
        for (int k = 0; k < 3; k++) step();
        chk("R1 subsec held before step", subsec, 9);
        step();
        chk("R1 subsec after first step", subsec, 8);

        // R2: one-second period at 127/255
        quiesce();
        cfg_async_div = 7'd127;
        cfg_sync_div = 15'd255;
        step();
        cfg_run = 1'b1;
        ticks = 0;
        for (int k = 0; k < 32766; k++) begin
            step();
            if (tick_1hz) ticks++;
        end
        chk("R2 no early tick", ticks, 0);
        step();
        chk("R2 first tick at 32767", tick_1hz, 1);
        ticks = 0;
        for (int k = 0; k < 32767; k++) begin
            step();
            if (tick_1hz) ticks++;
        end
        chk("R2 no tick inside period", ticks, 0);
        step();
        chk("R2 second tick after 32768", tick_1hz, 1);

        // R5/R6: divided-clock selects, reload 2, first and second expiry
        for (int c = 0; c < 4; c++) begin
            int per;
            per = 3 * (16 >> c);
            quiesce();
            cfg_wk_sel = 3'(c);
            cfg_wk_reload = 16'd2;
            step();
            cfg_wk_en = 1'b1;
            for (int k = 0; k < per - 1; k++) step();
            chk($sformatf("R5 sel%0d not yet", c), wk_flag, 0);
            step();
            chk($sformatf("R5 sel%0d first expiry", c), wk_flag, 1);
            wk_clr = 1'b1;
            step();
            wk_clr = 1'b0;
            for (int k = 0; k < per - 2; k++) step();
            chk($sformatf("R6 sel%0d before second", c), wk_flag, 0);
            step();
            chk($sformatf("R6 sel%0d periodic expiry", c), wk_flag, 1);
        end

        // R5: code 5 steps on the calendar tick (tick every 4 cycles), reload 1
        quiesce();
        cfg_async_div = 7'd1;
        cfg_sync_div = 15'd1;
        cfg_wk_sel = 3'd5;
        cfg_wk_reload = 16'd1;
        step();
        cfg_run = 1'b1;
        cfg_wk_en = 1'b1;
        for (int k = 0; k < 7; k++) step();
        chk("R5 tick source not yet", wk_flag, 0);
        step();
        chk("R5 tick source expiry", wk_flag, 1);

        // R6: disabled timer never sets the flag
        quiesce();
        cfg_wk_sel = 3'd3;
        cfg_wk_reload = 16'd0;
        for (int k = 0; k < 50; k++) step();
        chk("R6 disabled no flag", wk_flag, 0);

        // R7: a clear wins on a quiet cycle, and an expiry wins over a clear
        cfg_wk_en = 1'b1;
        step();
        step();
        chk("R7 flag set", wk_flag, 1);
        wk_clr = 1'b1;
        step();
        chk("R7 clear on quiet cycle", wk_flag, 0);
        step();
        chk("R7 set wins over clear", wk_flag, 1);
        wk_clr = 1'b0;
        cfg_wk_en = 1'b0;
        step();
        chk("R7 flag held without clear", wk_flag, 1);

        // R8: interrupt mask
        cfg_wk_irq_en = 1'b0;
        #1;
        chk("R8 masked irq", wk_irq, 0);
        cfg_wk_irq_en = 1'b1;
        #1;
        chk("R8 open irq", wk_irq, 1);
        wk_clr = 1'b1;
        step();
        wk_clr = 1'b0;
        chk("R8 irq drops with flag", wk_irq, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule